// File: doc/BRIEF.md
# Circular Stack with Cached Top Registers

This block is an 18-bit last-in-first-out stack for a small processor core. The topmost entries sit in dedicated registers whose contents are visible on output ports without a clock delay. Entries pushed deeper sit in a ring buffer of eight words. The ring wraps freely: it never reports full or empty. On overflow a stale slot is overwritten. On underflow an old value comes back.

A parameter picks one of two forms. The data-stack form keeps two cached top registers, so an arithmetic unit can read both operands at once. The return-stack form keeps one cached register, which suits a return address or loop count. Each clock takes one command: push, pop, replace the top, or do nothing. Opcode decoding and arithmetic belong to the surrounding core.

Top module: `cstack_top`

## Requirements
- R1: A synchronous active-high reset sets every cached top register to zero and sets the ring pointer to slot 0, so the first push after reset spills into slot 1.
- R2: Command code 2'b01 (push) loads the write data into the first top register. In the two-register form, the old first top register moves into the second. The deepest cached register spills into the ring slot one above the pointer, and the pointer advances to that slot.
- R3: Command code 2'b10 (pop) moves the second top register into the first in the two-register form. The deepest cached register is then refilled from the ring slot at the pointer, and the pointer steps back by one, modulo 8.
- R4: Command code 2'b11 (replace) writes the write data into the first top register only. The second top register, the pointer and the ring keep their values, so later pops return the same deeper data.
- R5: Command code 2'b00 (nop) leaves every top register, the pointer and the ring unchanged.
- R6: After more than eight spills without pops, the oldest ring entries are overwritten. Pops then return the last eight spilled values in reverse order, and no error output exists.
- R7: Popping past the stored depth returns earlier ring contents in cyclic order. The pointer wraps from slot 0 to slot 7.
- R8: With one cached register (NTOP = 1), the first top register behaves as in R2 to R5, spilling to and refilling from the ring itself. The second top output reads zero at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 2 | Command: 00 nop, 01 push, 10 pop, 11 replace |
| wdata | input | 18 | Value for push and replace |
| top0 | output | 18 | First (topmost) cached register |
| top1 | output | 18 | Second cached register; zero in the one-register form |

## Verification
Every command takes effect on the rising edge where it is sampled, and the cached registers drive the outputs directly. The new top values are therefore due at that same edge, with no added latency. The driver applies each command on a falling edge and queues the expected register values. The monitor pops that entry 2 ns after the next rising edge, so each comparison lands in the cycle its command produced. Ring slots that the model has not written since reset are tracked as unknown, and any value that comes from such a slot is not compared.

// File: rtl/cstack_pkg.sv
package cstack_pkg;

    typedef enum logic [1:0] {
        CMD_NOP  = 2'b00,
        CMD_PUSH = 2'b01,
        CMD_POP  = 2'b10,
        CMD_REPL = 2'b11
    } stk_cmd_e;

    function automatic bit is_pow2(input int n);
        return (n > 1) && ((n & (n - 1)) == 0);
    endfunction

endpackage

// File: rtl/cstack_ptr.sv
module cstack_ptr
    import cstack_pkg::*;
#(
    parameter int PW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  stk_cmd_e      cmd,
    output logic [PW-1:0] ptr,
    output logic [PW-1:0] ptr_up
);
    logic [PW-1:0] ptr_q;

    assign ptr    = ptr_q;
    assign ptr_up = ptr_q + PW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else begin
            unique case (cmd)
                CMD_PUSH: ptr_q <= ptr_up;
                CMD_POP:  ptr_q <= ptr_q - PW'(1);
                default:  ptr_q <= ptr_q;
            endcase
        end
    end
endmodule

// File: rtl/cstack_ring.sv
module cstack_ring #(
    parameter int W     = 18,
    parameter int DEPTH = 8,
    parameter int PW    = 3
) (
    input  logic          clk,
    input  logic          we,
    input  logic [PW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [PW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/cstack_tops.sv
module cstack_tops
    import cstack_pkg::*;
#(
    parameter int W    = 18,
    parameter int NTOP = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  stk_cmd_e     cmd,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] refill,
    output logic [W-1:0] top0,
    output logic [W-1:0] top1,
    output logic [W-1:0] spill
);
    logic [W-1:0] t0_q;
    logic [W-1:0] t1_q;

    generate
        if (NTOP == 2) begin : g_two
            always_ff @(posedge clk) begin
                if (rst) begin
                    t0_q <= '0;
                    t1_q <= '0;
                end else begin
                    unique case (cmd)
                        CMD_PUSH: begin t1_q <= t0_q;   t0_q <= wdata; end
                        CMD_POP:  begin t0_q <= t1_q;   t1_q <= refill; end
                        CMD_REPL: t0_q <= wdata;
                        default:  ;
                    endcase
                end
            end
            assign spill = t1_q;
        end else begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    t0_q <= '0;
                end else begin
                    unique case (cmd)
                        CMD_PUSH, CMD_REPL: t0_q <= wdata;
                        CMD_POP:            t0_q <= refill;
                        default:            ;
                    endcase
                end
            end
            assign t1_q  = '0;
            assign spill = t0_q;
        end
    endgenerate

    assign top0 = t0_q;
    assign top1 = t1_q;
endmodule

// File: rtl/cstack_top.sv
module cstack_top
    import cstack_pkg::*;
#(
    parameter int W     = 18,
    parameter int DEPTH = 8,
    parameter int NTOP  = 2,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   cmd,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] top0,
    output logic [W-1:0] top1
);
    stk_cmd_e      c;
    logic [PW-1:0] ptr_q;
    logic [PW-1:0] ptr_up;
    logic [W-1:0]  spill;
    logic [W-1:0]  refill;

    assign c = stk_cmd_e'(cmd);

    initial begin
        if (!is_pow2(DEPTH)) $error("DEPTH must be a power of two");
        if (NTOP != 1 && NTOP != 2) $error("NTOP must be 1 or 2");
    end

    cstack_ptr #(.PW(PW)) u_ptr (
        .clk    (clk),
        .rst    (rst),
        .cmd    (c),
        .ptr    (ptr_q),
        .ptr_up (ptr_up)
    );

    cstack_ring #(.W(W), .DEPTH(DEPTH), .PW(PW)) u_ring (
        .clk   (clk),
        .we    (c == CMD_PUSH),
        .waddr (ptr_up),
        .wdata (spill),
        .raddr (ptr_q),
        .rdata (refill)
    );

    cstack_tops #(.W(W), .NTOP(NTOP)) u_tops (
        .clk    (clk),
        .rst    (rst),
        .cmd    (c),
        .wdata  (wdata),
        .refill (refill),
        .top0   (top0),
        .top1   (top1),
        .spill  (spill)
    );
endmodule

// File: rtl/cstack_chk.sv
module cstack_chk
    import cstack_pkg::*;
#(
    parameter int W    = 18,
    parameter int NTOP = 2,
    parameter int PW   = 3
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    cmd,
    input logic [W-1:0]  wdata,
    input logic [W-1:0]  top0,
    input logic [W-1:0]  top1,
    input logic [PW-1:0] ptr_q
);
    p_push_top_r2: assert property (@(posedge clk) disable iff (rst)
        cmd == CMD_PUSH |=> top0 == $past(wdata));

    p_push_shift_r2: assert property (@(posedge clk) disable iff (rst)
        (NTOP == 2 && cmd == CMD_PUSH) |=> top1 == $past(top0));

    p_pop_shift_r3: assert property (@(posedge clk) disable iff (rst)
        (NTOP == 2 && cmd == CMD_POP) |=> top0 == $past(top1));

    p_repl_top_r4: assert property (@(posedge clk) disable iff (rst)
        cmd == CMD_REPL |=> (top0 == $past(wdata)) && $stable(top1) && $stable(ptr_q));

    p_nop_hold_r5: assert property (@(posedge clk) disable iff (rst)
        cmd == CMD_NOP |=> $stable(top0) && $stable(top1) && $stable(ptr_q));

    p_ptr_wrap_up_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_PUSH && ptr_q == '1) |=> ptr_q == '0);

    p_ptr_wrap_down_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_POP && ptr_q == '0) |=> ptr_q == '1);

    p_single_zero_r8: assert property (@(posedge clk) disable iff (rst)
        NTOP == 1 |-> top1 == '0);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (top0 == '0) && (top1 == '0) && (ptr_q == '0));
endmodule

bind cstack_top cstack_chk #(.W(W), .NTOP(NTOP), .PW(PW)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .cmd   (cmd),
    .wdata (wdata),
    .top0  (top0),
    .top1  (top1),
    .ptr_q (ptr_q)
);

// File: tb/cstack_top_test.sv
`timescale 1ns/1ps
module cstack_top_test;
    localparam int W = 18;
    localparam int D = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   cmd = 2'b00;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] d_top0, d_top1, r_top0, r_top1;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    cstack_top #(.W(W), .DEPTH(D), .NTOP(2)) uut (
        .clk(clk), .rst(rst), .cmd(cmd), .wdata(wdata), .top0(d_top0), .top1(d_top1));

    cstack_top #(.W(W), .DEPTH(D), .NTOP(1)) uut_ret (
        .clk(clk), .rst(rst), .cmd(cmd), .wdata(wdata), .top0(r_top0), .top1(r_top1));

    typedef struct {
        logic [W-1:0] e0, e1, er;
        bit v0, v1, vr;
        string tag;
    } exp_t;
    exp_t q[$];

    // reference model state
    logic [W-1:0] m_d0, m_d1, m_r0;
    bit           m_dv0, m_dv1, m_rv0;
    logic [W-1:0] m_dring [D];
    bit           m_dval  [D];
    logic [W-1:0] m_rring [D];
    bit           m_rval  [D];
    int           m_dp, m_rp;

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %05h expected %05h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_d0 = '0; m_d1 = '0; m_r0 = '0;
        m_dv0 = 1; m_dv1 = 1; m_rv0 = 1;
        m_dp = 0; m_rp = 0;
        for (int i = 0; i < D; i++) begin
            m_dval[i] = 0;
            m_rval[i] = 0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        cmd = 2'b00;
        model_reset();
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: tops cleared
        check("R1 top0", d_top0, '0);
        check("R1 top1", d_top1, '0);
        check("R1 ret top0", r_top0, '0);
    endtask

    // driver: apply one command and queue its expected outcome
    task automatic step(input logic [1:0] c, input logic [W-1:0] d, input string tag);
        exp_t e;
        @(negedge clk);
        cmd   = c;
        wdata = d;
        case (c)
            2'b01: begin
                m_dp = (m_dp + 1) % D;
                m_dring[m_dp] = m_d1; m_dval[m_dp] = m_dv1;
                m_d1 = m_d0; m_dv1 = m_dv0;
                m_d0 = d;    m_dv0 = 1;
                m_rp = (m_rp + 1) % D;
                m_rring[m_rp] = m_r0; m_rval[m_rp] = m_rv0;
                m_r0 = d;    m_rv0 = 1;
            end
            2'b10: begin
                m_d0 = m_d1; m_dv0 = m_dv1;
                m_d1 = m_dring[m_dp]; m_dv1 = m_dval[m_dp];
                m_dp = (m_dp + D - 1) % D;
                m_r0 = m_rring[m_rp]; m_rv0 = m_rval[m_rp];
                m_rp = (m_rp + D - 1) % D;
            end
            2'b11: begin
                m_d0 = d; m_dv0 = 1;
                m_r0 = d; m_rv0 = 1;
            end
            default: ;
        endcase
        e.e0 = m_d0; e.e1 = m_d1; e.er = m_r0;
        e.v0 = m_dv0; e.v1 = m_dv1; e.vr = m_rv0;
        e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: compare each queued expectation just after its edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                if (e.v0) check({e.tag, " top0"}, d_top0, e.e0);
                if (e.v1) check({e.tag, " top1"}, d_top1, e.e1);
                if (e.vr) check({e.tag, " R8 ret top0"}, r_top0, e.er);
                check("R8 ret top1 zero", r_top1, '0);
            end
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #4_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] lfsr;
        lfsr = 32'h1ACE_B00C;
        model_reset();
        do_reset();

        // R2 push a few values
        step(2'b01, 18'h00011, "R2");
        step(2'b01, 18'h00022, "R2");
        step(2'b01, 18'h00033, "R2");
        // R5 nop holds
        step(2'b00, 18'h3FFFF, "R5");
        step(2'b00, 18'h12345, "R5");
        // R4 replace then pops still see deeper data
        step(2'b11, 18'h2AAAA, "R4");
        step(2'b10, 18'h0, "R3/R4");
        step(2'b10, 18'h0, "R3");
        step(2'b10, 18'h0, "R3");

        // R6 overflow: 12 pushes into an 8-slot ring
        for (int i = 0; i < 12; i++) step(2'b01, 18'h10000 + W'(i * 7 + 1), "R6");
        for (int i = 0; i < 11; i++) step(2'b10, 18'h0, "R6");
        // R7 underflow: keep popping past the stored depth
        for (int i = 0; i < 12; i++) step(2'b10, 18'h0, "R7");
        step(2'b01, 18'h0ABCD, "R7");
        step(2'b10, 18'h0, "R7");

        // mixed long sequence
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step(lfsr[1:0], lfsr[W+1:2], "R6/R7 mix");
        end

        // R1 again after activity: pointer restarts at slot 0
        step(2'b00, 18'h0, "R5");
        repeat (3) @(negedge clk);
        do_reset();
        step(2'b01, 18'h00101, "R1/R2");
        step(2'b01, 18'h00202, "R1/R2");
        step(2'b01, 18'h00303, "R1/R2");
        step(2'b10, 18'h0, "R1/R3");
        step(2'b10, 18'h0, "R1/R3");
        step(2'b00, 18'h0, "R5");
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule